// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block is the status and control word that sits beside a floating-point datapath. Software reads and writes it as one 32-bit value through a system-register port. The word holds three parallel six-bit exception groups, a rounding-mode selector and a denormal-handling control bit.

The three groups each follow their own update rule:
- **Cause** records the outcome of the most recent instruction only.
- **Sticky flags** accumulate conditions across a run of instructions.
- **Enable** is set by software and decides which causes trap.

When an instruction completes, the datapath pulses a completion strobe together with a six-bit vector of exception conditions. Only the invalid-operation and divide-by-zero conditions are implemented. The other four slots exist in the layout but are tied to zero. When a freshly recorded cause meets its enable bit, the block raises a one-cycle exception request.

Top module: `fpx_status_reg`

## Requirements
- R1: After reset the read value is 32'h0000_0000: rounding mode 0 (nearest), denormal control 0, and every cause, enable and flag bit 0.
- R2: Read layout:
  - bits [1:0] rounding mode;
  - bit 2 denormal control;
  - bits [8:3] sticky flags;
  - bits [14:9] enable;
  - bits [20:15] cause;
  - bits [31:21] always read 0.

  Inside each group, index 0 is inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid, 5 unit error.
- R3: A software write loads the rounding mode, denormal control and all six enable bits. For cause and flags it loads only the divide-by-zero and invalid bits. Written values for cause and flag indices 0, 1, 2 and 5 are ignored, and those bits read 0.
- R4: On a completion strobe with no write in the same cycle, the whole cause group is rewritten. Indices 3 and 4 take the reported conditions, and all other cause bits become 0. The new value is visible from the next cycle on.
- R5: On a completion strobe, each flag bit becomes the OR of its old value and the reported condition (indices 3 and 4 only). An instruction never clears a flag.
- R6: Only a software write can clear a flag bit.
- R7: When a software write and a completion strobe coincide, the write wins. The instruction's cause, flag and trap effects are discarded.
- R8: `trap_req` is high for exactly the cycle after a completion strobe, and only when that instruction's reported conditions AND the enable bits AND the implemented mask (indices 3 and 4) are nonzero.
- R9: Condition inputs have no effect on cause, flags or `trap_req` in cycles without a completion strobe.
- R10: Rounding mode, denormal control and enable change only on a software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write value |
| rd_data | output | 32 | Current register value |
| ins_done | input | 1 | Instruction completion strobe |
| ins_exc | input | 6 | Conditions raised by the completing instruction, indexed as in R2 |
| trap_req | output | 1 | One-cycle exception request |

## Verification
The bench targets the following corner cases, with the failure each one exposes:
- **Write coinciding with completion.** A design that merged the two would leave a stale cause or flag behind, or fire a trap that should have been dropped.
- **A clean instruction after a faulting one.** A cause that was not fully rewritten stays set. A flag group that was copied instead of ORed loses its history.
- **All-ones writes and all-ones condition vectors.** A leak into the unimplemented indices shows up as stray ones in the read value.
- **Conditions presented without a strobe.** A design that ignored the strobe would change cause or pulse a trap in those cycles.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   localparam int unsigned GRP_W      = 6;
   localparam int unsigned IDX_INEXACT = 0;
   localparam int unsigned IDX_UNDER   = 1;
   localparam int unsigned IDX_OVER    = 2;
   localparam int unsigned IDX_DIVZ    = 3;
   localparam int unsigned IDX_INVALID = 4;
   localparam int unsigned IDX_ERROR   = 5;
   localparam logic [GRP_W-1:0] IMPL_DEFAULT =
      (GRP_W'(1) << IDX_DIVZ) | (GRP_W'(1) << IDX_INVALID);

   typedef enum logic [1:0] {
      RND_NEAREST = 2'd0,
      RND_ZERO    = 2'd1,
      RND_PLUS    = 2'd2,
      RND_MINUS   = 2'd3
   } rnd_mode_e;
endpackage

// File: rtl/fpx_cause_unit.sv
module fpx_cause_unit #(
   parameter int unsigned GRP_W = 6,
   parameter logic [GRP_W-1:0] IMPL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_wr,
   input  logic [GRP_W-1:0] sw_val,
   input  logic             ins_done,
   input  logic [GRP_W-1:0] ins_exc,
   output logic [GRP_W-1:0] cause_q
);
   logic [GRP_W-1:0] unused_bits;

   for (genvar i = 0; i < GRP_W; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        cause_q[i] <= 1'b0;
            else if (sw_wr)    cause_q[i] <= sw_val[i];
            else if (ins_done) cause_q[i] <= ins_exc[i];
         end
         assign unused_bits[i] = 1'b0;
      end else begin : g_tied
         assign cause_q[i]     = 1'b0;
         assign unused_bits[i] = sw_val[i] ^ ins_exc[i];
      end
   end

   AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ins_done && !sw_wr) |=> $stable(cause_q)); // R9
endmodule

// File: rtl/fpx_sticky_unit.sv
module fpx_sticky_unit #(
   parameter int unsigned GRP_W = 6,
   parameter logic [GRP_W-1:0] IMPL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_wr,
   input  logic [GRP_W-1:0] sw_val,
   input  logic             ins_done,
   input  logic [GRP_W-1:0] ins_exc,
   output logic [GRP_W-1:0] flag_q
);
   logic [GRP_W-1:0] unused_bits;

   for (genvar i = 0; i < GRP_W; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q[i] <= 1'b0;
            else if (sw_wr)    flag_q[i] <= sw_val[i];
            else if (ins_done) flag_q[i] <= flag_q[i] | ins_exc[i];
         end
         assign unused_bits[i] = 1'b0;
      end else begin : g_tied
         assign flag_q[i]      = 1'b0;
         assign unused_bits[i] = sw_val[i] ^ ins_exc[i];
      end
   end

   AST_FLAG_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R6
endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen #(
   parameter int unsigned GRP_W = 6,
   parameter logic [GRP_W-1:0] IMPL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_wr,
   input  logic             ins_done,
   input  logic [GRP_W-1:0] ins_exc,
   input  logic [GRP_W-1:0] enable,
   output logic             trap_req
);
   logic hit;
   assign hit = ins_done & ~sw_wr & (|(ins_exc & enable & IMPL_MASK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trap_req <= 1'b0;
      else        trap_req <= hit;
   end

   AST_TRAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> $past(ins_done)); // R8
   AST_TRAP_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> !$past(sw_wr)); // R7
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned GRP_W  = fpx_pkg::GRP_W,
   parameter int unsigned RND_W  = 2,
   parameter logic [GRP_W-1:0] IMPL_MASK = fpx_pkg::IMPL_DEFAULT,
   parameter logic [RND_W-1:0] RST_RND   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_wr,
   input  logic [DATA_W-1:0] sw_wdata,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ins_done,
   input  logic [GRP_W-1:0]  ins_exc,
   output logic              trap_req
);
   localparam int unsigned DN_POS  = RND_W;
   localparam int unsigned FLG_LSB = DN_POS + 1;
   localparam int unsigned EN_LSB  = FLG_LSB + GRP_W;
   localparam int unsigned CAU_LSB = EN_LSB + GRP_W;
   localparam int unsigned USED_W  = CAU_LSB + GRP_W;

   if (USED_W > DATA_W) begin : g_chk_fit
      $error("fpx_status_reg: fields need %0d bits, word has %0d", USED_W, DATA_W);
   end
   if (RND_W < 1) begin : g_chk_rnd
      $error("fpx_status_reg: RND_W must be at least 1");
   end

   logic [RND_W-1:0] rnd_q;
   logic             dn_q;
   logic [GRP_W-1:0] en_q;
   logic [GRP_W-1:0] cause_q;
   logic [GRP_W-1:0] flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rnd_q <= RST_RND;
         dn_q  <= 1'b0;
         en_q  <= '0;
      end else if (sw_wr) begin
         rnd_q <= sw_wdata[RND_W-1:0];
         dn_q  <= sw_wdata[DN_POS];
         en_q  <= sw_wdata[EN_LSB +: GRP_W];
      end
   end

   fpx_cause_unit #(.GRP_W(GRP_W), .IMPL_MASK(IMPL_MASK)) u_cause (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr),
      .sw_val(sw_wdata[CAU_LSB +: GRP_W]),
      .ins_done(ins_done), .ins_exc(ins_exc), .cause_q(cause_q));

   fpx_sticky_unit #(.GRP_W(GRP_W), .IMPL_MASK(IMPL_MASK)) u_sticky (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr),
      .sw_val(sw_wdata[FLG_LSB +: GRP_W]),
      .ins_done(ins_done), .ins_exc(ins_exc), .flag_q(flag_q));

   fpx_trap_gen #(.GRP_W(GRP_W), .IMPL_MASK(IMPL_MASK)) u_trap (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .ins_done(ins_done),
      .ins_exc(ins_exc), .enable(en_q), .trap_req(trap_req));

   always_comb begin
      rd_data                    = '0;
      rd_data[RND_W-1:0]         = rnd_q;
      rd_data[DN_POS]            = dn_q;
      rd_data[FLG_LSB +: GRP_W]  = flag_q;
      rd_data[EN_LSB +: GRP_W]   = en_q;
      rd_data[CAU_LSB +: GRP_W]  = cause_q;
   end

   if (USED_W < DATA_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^sw_wdata[DATA_W-1:USED_W];
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_wr |=> ($stable(rnd_q) && $stable(dn_q) && $stable(en_q))); // R10
   AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_done && !sw_wr) |=> ((rd_data[FLG_LSB +: GRP_W] & $past(flag_q)) == $past(flag_q))); // R5
   AST_CAUSE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_done && !sw_wr) |=> (rd_data[CAU_LSB +: GRP_W] == ($past(ins_exc) & IMPL_MASK))); // R4
endmodule

// File: tb/fpx_status_reg_tb.sv
`timescale 1ns/1ps
module fpx_status_reg_tb_top;
   localparam logic [5:0] IMPL = 6'b011000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_wr = 1'b0;
   logic [31:0] sw_wdata = '0;
   logic [31:0] rd_data;
   logic        ins_done = 1'b0;
   logic [5:0]  ins_exc = '0;
   logic        trap_req;

   int checks = 0;
   int errors = 0;

   logic [1:0] m_rnd;
   logic       m_dn;
   logic [5:0] m_en, m_cause, m_flag;
   logic       m_trap;

   always #2.5 clk = ~clk;

   fpx_status_reg dut_i (
      .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
      .rd_data(rd_data), .ins_done(ins_done), .ins_exc(ins_exc),
      .trap_req(trap_req));

   function automatic logic [31:0] pack_exp();
      logic [31:0] v;
      v = '0;
      v[1:0]   = m_rnd;
      v[2]     = m_dn;
      v[8:3]   = m_flag;
      v[14:9]  = m_en;
      v[20:15] = m_cause;
      return v;
   endfunction

   function automatic void model_step(logic wr, logic [31:0] d, logic done, logic [5:0] exc);
      if (wr) begin
         m_rnd = d[1:0]; m_dn = d[2]; m_en = d[14:9];
         m_cause = d[20:15] & IMPL; m_flag = d[8:3] & IMPL; m_trap = 1'b0;
      end else if (done) begin
         m_trap  = |(exc & IMPL & m_en);
         m_cause = exc & IMPL;
         m_flag  = m_flag | (exc & IMPL);
      end else begin
         m_trap = 1'b0;
      end
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Called at a negedge: drive, let one posedge pass, check at the next negedge.
   task automatic step(string tag, logic wr, logic [31:0] d, logic done, logic [5:0] exc);
      sw_wr = wr; sw_wdata = d; ins_done = done; ins_exc = exc;
      model_step(wr, d, done, exc);
      @(negedge clk);
      check({tag, " read"}, rd_data, pack_exp());
      check({tag, " trap"}, {31'd0, trap_req}, {31'd0, m_trap});
      sw_wr = 1'b0; ins_done = 1'b0; ins_exc = '0;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd7;
      void'($urandom(seed));
      m_rnd = 2'd0; m_dn = 1'b0; m_en = '0; m_cause = '0; m_flag = '0; m_trap = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset value
      check("R1 reset", rd_data, 32'h0);
      check("R1 trap", {31'd0, trap_req}, 32'h0);
      // R2/R3: all-ones write keeps only implemented cause/flag bits
      step("R3 ones", 1'b1, 32'hFFFF_FFFF, 1'b0, 6'h00);
      check("R2 upper zero", {11'd0, rd_data[31:21]}, 32'h0);
      // R6: clear everything by a write
      step("R6 clear", 1'b1, 32'h0000_0000, 1'b0, 6'h00);
      // R3: enable invalid only, rounding 2, denormal 1
      step("R3 ctrl", 1'b1, (32'h1 << (9 + 4)) | 32'h6, 1'b0, 6'h00);
      // R8: invalid with enable -> trap
      step("R8 trap inv", 1'b0, 32'h0, 1'b1, 6'b010000);
      // R8: divzero without enable -> no trap, R5 flag accumulates
      step("R8 no trap divz", 1'b0, 32'h0, 1'b1, 6'b001000);
      // R4/R5: clean instruction clears cause, keeps flags
      step("R4 clean", 1'b0, 32'h0, 1'b1, 6'h00);
      // R9: conditions without strobe ignored
      step("R9 idle", 1'b0, 32'h0, 1'b0, 6'h3F);
      // R4: all conditions on unimplemented bits ignored
      step("R4 all ones exc", 1'b0, 32'h0, 1'b1, 6'h3F);
      // R7: write and completion coincide
      step("R7 collide", 1'b1, 32'h1 << (9 + 3), 1'b1, 6'h3F);
      // R10: control fields survive instructions
      step("R10 keep", 1'b0, 32'h0, 1'b1, 6'b001000);
      // R6: flags survive clean instruction, then cleared by write
      step("R5 sticky", 1'b0, 32'h0, 1'b1, 6'h00);
      step("R6 write clear", 1'b1, 32'h0000_1E00, 1'b0, 6'h00);
      // Random traffic (R4, R5, R7, R8)
      for (int i = 0; i < 400; i++) begin
         logic wr, dn;
         wr = ($urandom % 8) == 0;
         dn = ($urandom % 2) == 0;
         step("R4 random", wr, $urandom, dn, 6'($urandom));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule